// File: doc/BRIEF.md
# Synchronous Rectifier Trigger Pulse Generator

This block sits on the primary side of a dual-switch forward converter. It takes the gate command from a PWM controller and a digital winding-detect signal, and it produces three outputs. The first is a delayed copy of the PWM command, which drives the primary switches. The second is a narrow turn-off pulse for the secondary synchronous rectifier driver. The third is a turn-on pulse for the same driver. Every time in the block is a number of clock cycles, derived from nanosecond parameters and the clock period.

Both raw inputs pass through a synchroniser before their edges are detected. Each edge of the PWM command fires a turn-off pulse after a short fixed delay. A turn-on pulse has two causes:
- the rising edge of the delayed switch drive, after a delay that is programmed at run time;
- the falling edge of the detect input, after a short fixed delay.

A detect trigger is never allowed to fire while a turn-off pulse is high. It is held, and it fires as soon as that pulse ends. Under heavy load this places the turn-on pulse right after the turn-off pulse. Under light load the turn-on pulse follows the detect edge directly.

Top module: `sr_trigger_gen`

## Requirements
- R1: A change of `pwm_in` sampled at clock edge n appears on `pwm_drv` after edge n+SYNC_STAGES-1+DRV_DELAY.
- R2: A change of `pwm_in` in either direction, sampled at edge n, raises `sr_off_pulse` after edge n+SYNC_STAGES+OFF_PD.
- R3: `sr_off_pulse` stays high for exactly ceil(OFF_WIDTH_NS*1000/CLK_PERIOD_PS) cycles (75 at the defaults).
- R4: When `pwm_drv` rises after edge t, `sr_on_pulse` rises after edge t+2+`dly_cfg`, where `dly_cfg` is an unsigned cycle count and 0 is allowed.
- R5: Suppose `det_in` falls (1 to 0) as sampled at edge n, and `sr_off_pulse` is low at that point. Then `sr_on_pulse` rises after edge n+SYNC_STAGES+DET_PD (light load).
- R6: A detect trigger that reaches the arbiter while `sr_off_pulse` is high is held. `sr_on_pulse` then rises one cycle after `sr_off_pulse` falls (heavy load).
- R7: `sr_on_pulse` stays high for exactly ceil(ON_WIDTH_NS*1000/CLK_PERIOD_PS) cycles (175 at the defaults).
- R8: A trigger that arrives while a pulse of the same kind is high is ignored, and the pulse keeps its length. A drive-edge start that arrives while the programmable delay is counting is also ignored.
- R9: In a normal switching period, each of the two pulse outputs is produced exactly twice.
- R10: While `rst_n` is low, all three outputs are low. Reset also discards a held detect trigger, so that trigger never fires later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Gate command from the PWM controller (asynchronous) |
| det_in | input | 1 | Winding-detect level (asynchronous) |
| dly_cfg | input | DLY_W | Extra cycles between a drive rising edge and its turn-on pulse; held stable while a delay runs |
| pwm_drv | output | 1 | Delayed copy of the PWM command for the primary switches |
| sr_off_pulse | output | 1 | Rectifier turn-off trigger pulse |
| sr_on_pulse | output | 1 | Rectifier turn-on trigger pulse |

## Verification
Full switching periods are run at two load levels:
- In the light-load periods the detect edge lands well after the second turn-off pulse. This separates the direct detect path from the held path, and it pins the detect latency.
- In the heavy-load periods the detect edge falls inside that turn-off pulse, so the turn-on pulse must appear exactly one cycle after the turn-off pulse ends.

Two values of the programmable delay are used, to tell a fixed offset apart from one that tracks the input. A short PWM glitch sends two triggers into one live turn-off pulse, which exposes any retriggering. A reset issued while a detect trigger is held shows whether that trigger leaks out afterwards.

// File: rtl/sr_trig_pkg.sv
`timescale 1ns/1ps
package sr_trig_pkg;
  // nanoseconds to whole clock cycles, rounding up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/sr_sync_edge.sv
`timescale 1ns/1ps
module sr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/sr_delay_line.sv
`timescale 1ns/1ps
module sr_delay_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else if (DEPTH == 1) begin : g_one
      logic sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b0;
        else        sh_q <= d_i;
      end
      assign q_o = sh_q;
    end else begin : g_many
      logic [DEPTH-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DEPTH-2:0], d_i};
      end
      assign q_o = sh_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sr_prog_delay.sv
`timescale 1ns/1ps
module sr_prog_delay #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dly_i,
  output logic         fire_o
);
  logic         busy_q;
  logic [W-1:0] cnt_q;

  assign fire_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= dly_i;
    end
  end

  // R8: a start while counting leaves the countdown untouched
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sr_pulse_timer.sv
`timescale 1ns/1ps
module sr_pulse_timer #(
  parameter int unsigned WIDTH = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WIDTH - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (trig_i) begin
      act_q <= 1'b1;
      cnt_q <= LOAD;
    end
  end

  assign pulse_o = act_q;

  // R8: retrigger during an active pulse neither restarts nor extends it
  p_retrig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && trig_i && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sr_trigger_gen.sv
`timescale 1ns/1ps
module sr_trigger_gen
  import sr_trig_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned OFF_WIDTH_NS  = 300,
  parameter int unsigned ON_WIDTH_NS   = 700,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DRV_DELAY     = 8,
  parameter int unsigned OFF_PD        = 3,
  parameter int unsigned DET_PD        = 3,
  parameter int unsigned DLY_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             det_in,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             pwm_drv,
  output logic             sr_off_pulse,
  output logic             sr_on_pulse
);
  localparam int unsigned OFF_CYC = ns_to_cyc(OFF_WIDTH_NS, CLK_PERIOD_PS);
  localparam int unsigned ON_CYC  = ns_to_cyc(ON_WIDTH_NS, CLK_PERIOD_PS);

  // synchronised levels and detected events
  logic pwm_lvl, pwm_prev, det_lvl, det_prev;
  logic pwm_edge, det_fall;
  logic drv_q, drv_prev_q, drv_rise;
  logic off_evt, det_evt, drv_fire;
  logic det_req, det_fire, pend_q, on_trig;

  sr_sync_edge #(.STAGES(SYNC_STAGES)) u_pwm_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pwm_in), .lvl_o(pwm_lvl), .prev_o(pwm_prev));
  sr_sync_edge #(.STAGES(SYNC_STAGES)) u_det_sync (
    .clk(clk), .rst_n(rst_n), .d_i(det_in), .lvl_o(det_lvl), .prev_o(det_prev));

  assign pwm_edge = pwm_lvl ^ pwm_prev;
  assign det_fall = det_prev & ~det_lvl;

  // delayed switch drive
  sr_delay_line #(.DEPTH(DRV_DELAY)) u_drv_line (
    .clk(clk), .rst_n(rst_n), .d_i(pwm_lvl), .q_o(drv_q));
  assign pwm_drv = drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_prev_q <= 1'b0;
    else        drv_prev_q <= drv_q;
  end
  assign drv_rise = drv_q & ~drv_prev_q;

  // short fixed propagation delays
  sr_delay_line #(.DEPTH(OFF_PD)) u_off_line (
    .clk(clk), .rst_n(rst_n), .d_i(pwm_edge), .q_o(off_evt));
  sr_delay_line #(.DEPTH(DET_PD)) u_det_line (
    .clk(clk), .rst_n(rst_n), .d_i(det_fall), .q_o(det_evt));

  // programmable delay from drive rising edge
  sr_prog_delay #(.W(DLY_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .start_i(drv_rise), .dly_i(dly_cfg), .fire_o(drv_fire));

  // detect arbiter: hold while turn-off pulse is high
  assign det_req  = det_evt | pend_q;
  assign det_fire = det_req & ~sr_off_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= det_req & sr_off_pulse;
  end

  assign on_trig = drv_fire | det_fire;

  sr_pulse_timer #(.WIDTH(OFF_CYC)) u_off_timer (
    .clk(clk), .rst_n(rst_n), .trig_i(off_evt), .pulse_o(sr_off_pulse));
  sr_pulse_timer #(.WIDTH(ON_CYC)) u_on_timer (
    .clk(clk), .rst_n(rst_n), .trig_i(on_trig), .pulse_o(sr_on_pulse));

  // R2: a turn-off pulse only starts from a delayed PWM edge event
  p_off_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_off_pulse) |-> $past(off_evt));

  // R6: a held detect trigger is released as soon as the off pulse is gone
  p_held_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sr_off_pulse && !sr_on_pulse) |=> sr_on_pulse);

  // R6: a detect event during the off pulse is held, not dropped
  p_det_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_evt && sr_off_pulse) |=> pend_q);

  // R10: outputs quiet while reset is applied
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!sr_off_pulse && !sr_on_pulse && !pwm_drv && !pend_q);
    end
  end
endmodule

// File: tb/test_sr_trigger_gen.sv
`timescale 1ns/1ps
module test_sr_trigger_gen;
  localparam int CLK_PS = 4000;
  localparam int S      = 2;
  localparam int DRV    = 8;
  localparam int PDO    = 3;
  localparam int PDD    = 3;
  localparam int OFF_CYC = int'($ceil(300.0 * 1000.0 / CLK_PS));
  localparam int ON_CYC  = int'($ceil(700.0 * 1000.0 / CLK_PS));
  localparam int HL = 64;

  logic clk = 1'b0, rst_n = 1'b0, pwm_in = 1'b0, det_in = 1'b0;
  logic [7:0] dly_cfg = 8'd0;
  logic pwm_drv, sr_off_pulse, sr_on_pulse;

  always #2 clk = ~clk;

  sr_trigger_gen #(.CLK_PERIOD_PS(CLK_PS), .SYNC_STAGES(S), .DRV_DELAY(DRV),
                   .OFF_PD(PDO), .DET_PD(PDD), .DLY_W(8)) i_sr_trigger_gen (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .det_in(det_in), .dly_cfg(dly_cfg),
    .pwm_drv(pwm_drv), .sr_off_pulse(sr_off_pulse), .sr_on_pulse(sr_on_pulse));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit ph[$], dh[$];
  int off_rem, on_rem, pd_cnt;
  bit pd_busy, pend, m_drv, m_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph.delete(); dh.delete();
      for (int i = 0; i < HL; i++) begin ph.push_back(1'b0); dh.push_back(1'b0); end
      off_rem = 0; on_rem = 0; pd_cnt = 0; pd_busy = 0; pend = 0; m_drv = 0; m_ok = 1;
    end else begin
      bit t_off, d_evt, st, ta, req, tb;
      ph.push_front(pwm_in); void'(ph.pop_back());
      dh.push_front(det_in); void'(dh.pop_back());
      t_off = ph[S+PDO] != ph[S+1+PDO];
      d_evt = !dh[S+PDD] && dh[S+1+PDD];
      st    = ph[S+DRV] && !ph[S+1+DRV];
      ta    = pd_busy && pd_cnt == 0;
      if (pd_busy) begin
        if (pd_cnt == 0) pd_busy = 0; else pd_cnt--;
      end else if (st) begin
        pd_busy = 1; pd_cnt = int'(dly_cfg);
      end
      req  = d_evt || pend;
      tb   = req && off_rem == 0;
      pend = req && off_rem > 0;
      if (off_rem > 0) off_rem--; else if (t_off) off_rem = OFF_CYC;
      if (on_rem > 0) on_rem--; else if (ta || tb) on_rem = ON_CYC;
      m_drv = ph[S-1+DRV];
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_ok) begin
      chk(pwm_drv == m_drv, "R1 drive copy", pwm_drv, m_drv);
      chk(sr_off_pulse == (off_rem > 0), "R2 R3 R8 off pulse", sr_off_pulse, off_rem > 0);
      chk(sr_on_pulse == (on_rem > 0), "R4 R5 R6 R7 on pulse", sr_on_pulse, on_rem > 0);
    end
  end

  // ---------------- event monitor ----------------
  int cyc = 0;
  int offr[$], offf[$], onr[$], onf[$];
  int drv_rise_cyc = -1, pwm_rise_cyc = -1, det_fall_cyc = -1;
  logic p_off = 0, p_on = 0, p_drv = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (sr_off_pulse && !p_off) offr.push_back(cyc);
    if (!sr_off_pulse && p_off) offf.push_back(cyc);
    if (sr_on_pulse && !p_on) onr.push_back(cyc);
    if (!sr_on_pulse && p_on) onf.push_back(cyc);
    if (pwm_drv && !p_drv) drv_rise_cyc = cyc;
    p_off = sr_off_pulse; p_on = sr_on_pulse; p_drv = pwm_drv;
  end

  task automatic clear_mon();
    offr.delete(); offf.delete(); onr.delete(); onf.delete();
    drv_rise_cyc = -1; pwm_rise_cyc = -1; det_fall_cyc = -1;
  endtask

  function automatic int qv(input int q[$], input int i);
    return (q.size() > i) ? q[i] : -9999;
  endfunction

  task automatic run_period(input int hi, input int det_after, input int tail);
    @(negedge clk);
    pwm_in = 1; det_in = 1; pwm_rise_cyc = cyc + 1;
    repeat (hi) @(negedge clk);
    pwm_in = 0;
    repeat (det_after) @(negedge clk);
    det_in = 0; det_fall_cyc = cyc + 1;
    repeat (tail) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    chk(!sr_off_pulse && !sr_on_pulse && !pwm_drv, "R10 reset state",
        {sr_off_pulse, sr_on_pulse, pwm_drv}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);

    // light load, zero programmable delay
    dly_cfg = 8'd0; clear_mon();
    run_period(300, 150, 400);
    chk(drv_rise_cyc - pwm_rise_cyc == S - 1 + DRV, "R1 drive latency",
        drv_rise_cyc - pwm_rise_cyc, S - 1 + DRV);
    chk(qv(offr, 0) - pwm_rise_cyc == S + PDO, "R2 off latency",
        qv(offr, 0) - pwm_rise_cyc, S + PDO);
    chk(qv(offf, 0) - qv(offr, 0) == OFF_CYC, "R3 off width",
        qv(offf, 0) - qv(offr, 0), OFF_CYC);
    chk(qv(onr, 0) - drv_rise_cyc == 2, "R4 on after drive, delay 0",
        qv(onr, 0) - drv_rise_cyc, 2);
    chk(qv(onr, 1) - det_fall_cyc == S + PDD, "R5 light-load detect latency",
        qv(onr, 1) - det_fall_cyc, S + PDD);
    chk(qv(onf, 0) - qv(onr, 0) == ON_CYC, "R7 on width",
        qv(onf, 0) - qv(onr, 0), ON_CYC);
    chk(offr.size() == 2, "R9 off pulses per period", offr.size(), 2);
    chk(onr.size() == 2, "R9 on pulses per period", onr.size(), 2);

    // heavy load, programmable delay 40
    dly_cfg = 8'd40; clear_mon();
    run_period(300, 20, 500);
    chk(qv(onr, 0) - drv_rise_cyc == 42, "R4 on after drive, delay 40",
        qv(onr, 0) - drv_rise_cyc, 42);
    chk(qv(onr, 1) - qv(offf, 1) == 1, "R6 held detect fires after off ends",
        qv(onr, 1) - qv(offf, 1), 1);
    chk(qv(onf, 1) - qv(onr, 1) == ON_CYC, "R7 held on width",
        qv(onf, 1) - qv(onr, 1), ON_CYC);
    chk(offr.size() == 2 && onr.size() == 2, "R9 heavy-load pulse counts",
        offr.size() * 10 + onr.size(), 22);

    // glitch: second PWM edge lands inside the live off pulse
    dly_cfg = 8'd5; clear_mon();
    @(negedge clk); pwm_in = 1;
    repeat (10) @(negedge clk); pwm_in = 0;
    repeat (400) @(negedge clk);
    chk(offr.size() == 1, "R8 retrigger ignored, count", offr.size(), 1);
    chk(qv(offf, 0) - qv(offr, 0) == OFF_CYC, "R8 retrigger ignored, width",
        qv(offf, 0) - qv(offr, 0), OFF_CYC);

    // reset while a detect trigger is held
    dly_cfg = 8'd0; clear_mon();
    @(negedge clk); pwm_in = 1; det_in = 1;
    repeat (300) @(negedge clk); pwm_in = 0;
    repeat (20) @(negedge clk); det_in = 0;
    repeat (PDD + 8) @(negedge clk);
    chk(sr_off_pulse == 1'b1, "R10 off still high before reset", sr_off_pulse, 1);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!sr_off_pulse && !sr_on_pulse, "R10 outputs low in reset",
        {sr_off_pulse, sr_on_pulse}, 0);
    rst_n = 1; clear_mon();
    repeat (300) @(negedge clk);
    chk(onr.size() == 0, "R10 held trigger discarded by reset", onr.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule